// File: doc/BRIEF.md
# Programmable Sinc Decimation Filter

This block turns a one-bit sigma-delta modulator stream into signed multi-bit conversion results. It is a cascaded integrator-comb filter of third or fourth order. Each output period spans 1024 times a 10-bit rate code of accepted modulator bits. The integrators run on every accepted bit. The combs run once per output period, with a differential delay of one.

A channel-change pulse clears all filter state and the period counter. It also latches the rate code and the order select. The block then withholds results until the filter has fully settled, which takes as many output periods as the filter order. After that it issues one result per output period until the next channel change. A step at the input with no channel change resets nothing: results keep coming at the programmed rate and reach the new level within the filter order's number of outputs.

Top module: `sinc_decimator`

## Requirements
- R1: Once settled, exactly one result is issued per 1024×code accepted input bits. `result_valid` is high for one clock, in the clock after the input bit that completes a period.
- R2: `third_order` = 1 selects the third-order response and 0 selects the fourth-order response.
- R3: After a channel change, the first result follows the input bit that completes period 3 (third order) or period 4 (fourth order). No result comes earlier.
- R4: A rate code of 0 latched at a channel change is invalid. No result is issued until a later channel change latches a code from 1 to 1023.
- R5: A channel change clears the integrators, the combs and the period counter, so history from before it has no effect on later results. A bit presented in the same cycle as the pulse is discarded.
- R6: Changes on `rate_code` or `third_order` between channel changes have no effect; both are taken only at a channel change.
- R7: Bit 1 counts as +1 and bit 0 as −1. The comb result, in wrap-around two's complement, is shifted right arithmetically by N·(10+⌈log2 code⌉)+2−24, where N is the order. Its low 24 bits form `result`, so a constant input of all ones gives +(1024·code)^N scaled by that shift, and all zeros gives the negative of it.
- R8: An input step with no channel change does not stop results. If the step falls on a period edge, the N-th result after it equals the settled value of the new level.
- R9: After `rst_n` is released, no result is issued until the first channel change.
- R10: Cycles with `mod_valid` low are not counted and do not change the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| mod_valid | input | 1 | Qualifies `mod_bit` in this cycle |
| rate_code | input | 10 | Decimation code; ratio is 1024 × code |
| third_order | input | 1 | 1: third order, 0: fourth order |
| chan_change | input | 1 | Clears the filter and latches the code and order |
| result | output | 24 | Signed conversion result |
| result_valid | output | 1 | One-clock strobe for `result` |

## Verification
A result is due one clock after the accepted input bit whose running count since the channel change reaches k×1024×code, with k at or above the order. The bench keeps its own count of accepted bits, cleared by the channel change. On every result strobe it records that count, read at the falling edge. It then compares both the value and the recorded count with figures worked out from the code and order. Scenarios are separated by two idle cycles, so a result left over from one scenario cannot be counted in the next.

// File: rtl/cic_pkg.sv
package cic_pkg;

   // smallest b with 2**b >= v (0 for v <= 1)
   function automatic int ceil_log2(input int v);
      int b;
      b = 0;
      for (int i = 0; i < 31; i++)
         if ((1 << i) < v) b = i + 1;
      return b;
   endfunction

endpackage

// File: rtl/cic_integrators.sv
module cic_integrators #(
   parameter int ACC_W  = 81,
   parameter int STAGES = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr,
   input  logic                           en,
   input  logic [ACC_W-1:0]               x,
   output logic [STAGES-1:0][ACC_W-1:0]   nxt
);

   logic [STAGES-1:0][ACC_W-1:0] acc_q;

   generate
      if (STAGES < 1) begin : g_bad
         $error("cic_integrators: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            assign nxt[s] = acc_q[s] + x;
         end else begin : g_rest
            assign nxt[s] = acc_q[s] + nxt[s-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   acc_q[s] <= '0;
            else if (clr) acc_q[s] <= '0;
            else if (en)  acc_q[s] <= nxt[s];
         end
      end
   endgenerate

   // R5
   integ_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));

endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
   parameter int ACC_W  = 81,
   parameter int STAGES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             drop_last,
   input  logic [ACC_W-1:0] x,
   output logic [ACC_W-1:0] y
);

   logic [STAGES:0][ACC_W-1:0]   d;
   logic [STAGES-1:0][ACC_W-1:0] dly_q;

   assign d[0] = x;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cic_combs: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         assign d[s+1] = d[s] - dly_q[s];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   dly_q[s] <= '0;
            else if (clr) dly_q[s] <= '0;
            else if (en)  dly_q[s] <= d[s];
         end
      end
   endgenerate

   assign y = drop_last ? d[STAGES-1] : d[STAGES];

   // R5
   comb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (dly_q == '0));

endmodule

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
   import cic_pkg::*;
#(
   parameter int BASE_LOG2 = 10,
   parameter int CODE_W    = 10,
   parameter int OUT_W     = 24,
   parameter int SH_W      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chg,
   input  logic [CODE_W-1:0] code,
   input  logic              sel_third,
   input  logic              in_valid,
   output logic              step_en,
   output logic              tick,
   output logic              emit,
   output logic              third,
   output logic [SH_W-1:0]   shift
);

   logic [CODE_W-1:0]    code_q;
   logic                 third_q;
   logic                 ok_q;
   logic [BASE_LOG2-1:0] lo_q;
   logic [CODE_W-1:0]    hi_q;
   logic [2:0]           per_q;
   logic [SH_W-1:0]      sh_q;
   logic [2:0]           need;
   logic                 lo_end, hi_end;
   int                   sh_calc;

   generate
      if (3 * BASE_LOG2 + 2 < OUT_W) begin : g_bad
         $error("cic_rate_ctrl: output wider than the smallest filter gain");
      end
   endgenerate

   assign need    = third_q ? 3'd3 : 3'd4;
   assign step_en = in_valid && ok_q && !chg;
   assign lo_end  = &lo_q;
   assign hi_end  = (hi_q == code_q - 1'b1);
   assign tick    = step_en && lo_end && hi_end;
   assign emit    = tick && (per_q >= need - 3'd1);
   assign third   = third_q;
   assign shift   = sh_q;

   always_comb
      sh_calc = (sel_third ? 3 : 4) * (BASE_LOG2 + ceil_log2(int'(code))) + 2 - OUT_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         third_q <= 1'b1;
         ok_q    <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
         per_q   <= '0;
         sh_q    <= '0;
      end else if (chg) begin
         code_q  <= code;
         third_q <= sel_third;
         ok_q    <= (code != '0);
         lo_q    <= '0;
         hi_q    <= '0;
         per_q   <= '0;
         sh_q    <= SH_W'(sh_calc);
      end else if (step_en) begin
         lo_q <= lo_q + 1'b1;
         if (lo_end) hi_q <= hi_end ? '0 : hi_q + 1'b1;
         if (tick && per_q < need) per_q <= per_q + 3'd1;
      end
   end

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chg |=> ($stable(code_q) && $stable(third_q)));

   // R4
   zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emit |-> (code_q != '0));

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> (hi_q < code_q));

endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
   parameter int BASE_LOG2 = 10,
   parameter int CODE_W    = 10,
   parameter int OUT_W     = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              mod_valid,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              third_order,
   input  logic              chan_change,
   output logic [OUT_W-1:0]  result,
   output logic              result_valid
);

   localparam int MAX_ORDER = 4;
   localparam int ACC_W     = MAX_ORDER * (BASE_LOG2 + CODE_W) + 1;
   localparam int SH_W      = $clog2(ACC_W);

   logic                             step_en, tick, emit, third;
   logic [SH_W-1:0]                  shift;
   logic [ACC_W-1:0]                 x;
   logic [MAX_ORDER-1:0][ACC_W-1:0]  integ;
   logic [ACC_W-1:0]                 comb_in, comb_out;
   logic signed [ACC_W-1:0]          scaled;

   generate
      if (OUT_W > ACC_W) begin : g_bad
         $error("sinc_decimator: OUT_W exceeds accumulator width");
      end
   endgenerate

   assign x = mod_bit ? ACC_W'(1) : '1;

   cic_rate_ctrl #(
      .BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W), .OUT_W(OUT_W), .SH_W(SH_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chg(chan_change), .code(rate_code),
      .sel_third(third_order), .in_valid(mod_valid),
      .step_en(step_en), .tick(tick), .emit(emit), .third(third), .shift(shift)
   );

   cic_integrators #(.ACC_W(ACC_W), .STAGES(MAX_ORDER)) u_integ (
      .clk(clk), .rst_n(rst_n), .clr(chan_change), .en(step_en),
      .x(x), .nxt(integ)
   );

   assign comb_in = third ? integ[MAX_ORDER-2] : integ[MAX_ORDER-1];

   cic_combs #(.ACC_W(ACC_W), .STAGES(MAX_ORDER)) u_comb (
      .clk(clk), .rst_n(rst_n), .clr(chan_change), .en(tick),
      .drop_last(third), .x(comb_in), .y(comb_out)
   );

   assign scaled = $signed(comb_out) >>> shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= emit;
         if (emit) result <= scaled[OUT_W-1:0];
      end
   end

   // R1
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R3
   settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_change |=> !result_valid);

   // R10
   idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_valid |=> !result_valid);

endmodule

// File: tb/sinc_decimator_test.sv
module sinc_decimator_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0;
   logic        mod_valid = 1'b0;
   logic [9:0]  rate_code = '0;
   logic        third_order = 1'b1;
   logic        chan_change = 1'b0;
   logic [23:0] result;
   logic        result_valid;

   int checks = 0;
   int errors = 0;
   int nin = 0;
   int cyc = 0;
   bit done = 0;
   int res_cnt = 0;
   int res_val [16];
   int res_n   [16];

   always #5 clk = ~clk;

   sinc_decimator uut (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_valid(mod_valid),
      .rate_code(rate_code), .third_order(third_order),
      .chan_change(chan_change), .result(result), .result_valid(result_valid)
   );

   always @(posedge clk)
      if (chan_change) nin <= 0;
      else if (mod_valid) nin <= nin + 1;

   always @(negedge clk)
      if (result_valid && res_cnt < 16) begin
         res_val[res_cnt] = $signed(result);
         res_n[res_cnt]   = nin;
         res_cnt++;
      end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below 190000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint full_scale(input int code, input int ord);
      longint r, p;
      int sh;
      r = 1024 * code;
      p = 1;
      for (int i = 0; i < ord; i++) p = p * r;
      sh = ord * (10 + $clog2(code)) + 2 - 24;
      return p >>> sh;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mod_valid = 1'b0;
      end
   endtask

   task automatic restart(input int code, input bit third);
      idle(2);
      res_cnt = 0;
      chan_change = 1'b1;
      rate_code = 10'(code);
      third_order = third;
      @(negedge clk);
      chan_change = 1'b0;
   endtask

   task automatic push(input bit b);
      @(negedge clk);
      mod_bit = b;
      mod_valid = 1'b1;
   endtask

   task automatic push_const(input bit b, input int n);
      for (int i = 0; i < n; i++) push(b);
   endtask

   // R9: reset state, then no output before a first channel change
   task automatic t_reset;
      chk("R9 reset valid", result_valid, 0);
      chk("R9 reset value", result, 0);
      res_cnt = 0;
      push_const(1'b1, 5000);
      idle(2);
      chk("R9 no result before channel change", res_cnt, 0);
   endtask

   // R1 R2 R3 R7: third order, code 1, all ones
   task automatic t_third_ones;
      restart(1, 1'b1);
      push_const(1'b1, 5 * 1024);
      idle(2);
      chk("R3 third-order result count", res_cnt, 3);
      chk("R3 first result at period 3", res_n[0], 3072);
      chk("R1 second result one period later", res_n[1], 4096);
      chk("R1 third result one period later", res_n[2], 5120);
      chk("R7 full-scale positive", res_val[0], full_scale(1, 3));
      chk("R2 third-order value", res_val[2], 4194304);
   endtask

   // R2 R3 R7: fourth order, code 1, all zeros
   task automatic t_fourth_zeros;
      restart(1, 1'b0);
      push_const(1'b0, 5 * 1024);
      idle(2);
      chk("R3 fourth-order result count", res_cnt, 2);
      chk("R3 first result at period 4", res_n[0], 4096);
      chk("R1 next result", res_n[1], 5120);
      chk("R7 full-scale negative", res_val[0], -full_scale(1, 4));
      chk("R2 fourth-order value", res_val[1], -4194304);
   endtask

   // R1 R7: code 3, period 3072
   task automatic t_code3;
      restart(3, 1'b1);
      push_const(1'b1, 4 * 3072);
      idle(2);
      chk("R1 code-3 result count", res_cnt, 2);
      chk("R1 code-3 first position", res_n[0], 9216);
      chk("R1 code-3 second position", res_n[1], 12288);
      chk("R7 code-3 value", res_val[1], 1769472);
   endtask

   // R4: code 0 is invalid
   task automatic t_zero_code;
      restart(0, 1'b1);
      push_const(1'b1, 4096);
      idle(2);
      chk("R4 no result with code 0", res_cnt, 0);
   endtask

   // R6: runtime changes ignored without channel change
   task automatic t_ignore_cfg;
      restart(1, 1'b1);
      push_const(1'b1, 100);
      rate_code = 10'd2;
      third_order = 1'b0;
      push_const(1'b1, 4096 - 100);
      idle(2);
      chk("R6 result count unchanged", res_cnt, 2);
      chk("R6 first position unchanged", res_n[0], 3072);
      chk("R6 value unchanged", res_val[1], 4194304);
   endtask

   // R5: channel change discards history
   task automatic t_clear_history;
      restart(1, 1'b0);
      push_const(1'b0, 2048 + 300);
      restart(1, 1'b0);
      push_const(1'b1, 4096);
      idle(2);
      chk("R5 result count after clear", res_cnt, 1);
      chk("R5 position after clear", res_n[0], 4096);
      chk("R5 value free of old history", res_val[0], 4194304);
   endtask

   // R8: step on a period edge, no channel change
   task automatic t_step;
      restart(1, 1'b1);
      push_const(1'b1, 4096);
      push_const(1'b0, 3072);
      idle(2);
      chk("R8 results keep flowing", res_cnt, 5);
      chk("R8 last position", res_n[4], 7168);
      chk("R8 settled after three results", res_val[4], -4194304);
   endtask

   // R10: idle cycles between bits are not counted
   task automatic t_gaps;
      restart(1, 1'b1);
      for (int i = 0; i < 3072; i++) begin
         push(i[0] ? 1'b0 : 1'b1);
         idle(1);
      end
      idle(2);
      chk("R10 result count with gaps", res_cnt, 1);
      chk("R10 position counts only valid bits", res_n[0], 3072);
      chk("R10 alternating bits give zero", res_val[0], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_third_ones();
      t_fourth_zeros();
      t_code3();
      t_zero_code();
      t_ignore_cfg();
      t_clear_history();
      t_step();
      t_gaps();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule